// File: doc/BRIEF.md
# Proximity Tag Identifier Frame Encoder

This block turns a 40-bit tag identifier into the 64-bit frame sent by a read-only low-frequency proximity tag. The frame starts with a run of ones that marks where it begins. The identifier follows as ten 4-bit rows, each with its own parity bit. After the rows come four column parity bits and a closing zero. The full frame is always on the outputs as two 32-bit words, built combinationally from the current identifier.

A serial port sends the same frame one bit at a time. A start pulse captures the frame into a shift register. Each bit-enable strobe then moves the line to the next bit, and busy stays high until all 64 bits have gone out. A repeat input makes the block send the captured frame again and again with no gap, the way a tag answers a reader continuously.

Top module: `prox_id_encoder`

## Requirements
- R1: Frame bits 63 down to 55 (the nine most significant bits of `frame_hi`) are all 1.
- R2: Row k (k = 0..9) sits at frame bits [54-5k : 50-5k]. Its top four bits are identifier nibble `tag_id[39-4k -: 4]`, so the most significant nibble comes first. Its lowest bit is the XOR of that nibble, which gives even parity.
- R3: Frame bits 4..1 hold column parity. Bit 1+j is the XOR of bit j of all ten nibbles, and row parity bits are not included.
- R4: Frame bit 0 is 0. `frame_hi` is frame bits 63..32 and `frame_lo` is bits 31..0. Both follow `tag_id` with no clock delay.
- R5: For `tag_id` = 0x0000001EBC, `frame_hi` = 0xFF800000 and `frame_lo` = 0x003EDF10.
- R6: A `start` sampled high while `busy` is low captures the current frame. `busy` is high from the next cycle, and `ser_out` then shows frame bit 63.
- R7: While `busy` is high, each clock edge with `bit_en` high moves `ser_out` to the next lower frame bit. Edges with `bit_en` low leave it unchanged.
- R8: The edge that consumes bit 0 with `rpt_en` low clears `busy` and raises `done` for exactly one cycle.
- R9: A `start` while `busy` is high has no effect. A change of `tag_id` during a transmission does not alter the bits being sent.
- R10: If `rpt_en` is high on the edge that consumes bit 0, `busy` stays high and the captured frame is sent again from bit 63 with no gap.
- R11: A synchronous active-high `rst` clears `busy` and `done` and drives `ser_out` to 0. While `busy` is low, `ser_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tag_id | input | 40 | Identifier to encode |
| start | input | 1 | Begin a serial transmission |
| bit_en | input | 1 | Bit-rate strobe that advances the serial output |
| rpt_en | input | 1 | Send the frame again after bit 0 |
| frame_hi | output | 32 | Frame bits 63..32 |
| frame_lo | output | 32 | Frame bits 31..0 |
| busy | output | 1 | A transmission is in progress |
| done | output | 1 | One-cycle pulse after the last bit |
| ser_out | output | 1 | Serial frame bit |

## Verification
The parallel words are combinational, so they are checked in the same cycle the identifier is applied. The serial outputs are registered. `busy` and the first bit appear one edge after `start`, each later bit appears one edge after a strobe, and `done` is high for the cycle right after the edge that consumes bit 0. The bench drives inputs just after a rising edge. A behavioural bit-queue model advances on the same edge, and the design is compared against it on the falling edge, so every expected value lines up with the register that produces it.

// File: rtl/prox_frame_pkg.sv
package prox_frame_pkg;

    localparam int NIB_W    = 4;
    localparam int NIB_CNT  = 10;
    localparam int ID_W     = NIB_W * NIB_CNT;
    localparam int HDR_LEN  = 9;
    localparam int ROW_W    = NIB_W + 1;
    localparam int DATA_W   = ROW_W * NIB_CNT;
    localparam int FRAME_W  = HDR_LEN + DATA_W + NIB_W + 1;
    localparam int HALF_W   = FRAME_W / 2;
    localparam int CNT_W    = $clog2(FRAME_W);

    typedef logic [NIB_W-1:0] nib_t;
    typedef logic [ROW_W-1:0] row_t;

    // Packed so that hdr lands in the most significant bits of the frame.
    typedef struct packed {
        logic [HDR_LEN-1:0] hdr;
        logic [DATA_W-1:0]  rows;
        nib_t               col;
        logic               stop;
    } frame_t;

    typedef enum logic [0:0] {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

    function automatic logic even_bit(input nib_t n);
        return ^n;
    endfunction

    function automatic row_t pack_row(input nib_t n);
        return {n, even_bit(n)};
    endfunction

endpackage

// File: rtl/prox_row_encoder.sv
module prox_row_encoder
    import prox_frame_pkg::*;
(
    input  nib_t nib,
    output row_t row,
    output logic par
);
    assign row = pack_row(nib);
    assign par = row[0];
endmodule

// File: rtl/prox_frame_build.sv
module prox_frame_build
    import prox_frame_pkg::*;
(
    input  logic [ID_W-1:0] id,
    output frame_t          frame
);
    logic [DATA_W-1:0]  rows_w;
    logic [NIB_CNT-1:0] row_par;
    nib_t               col_par;

    genvar g;
    generate
        for (g = 0; g < NIB_CNT; g++) begin : g_row
            prox_row_encoder u_row (
                .nib (id[ID_W-1-g*NIB_W -: NIB_W]),
                .row (rows_w[DATA_W-1-g*ROW_W -: ROW_W]),
                .par (row_par[g])
            );
        end
    endgenerate

    always_comb begin
        col_par = '0;
        for (int k = 0; k < NIB_CNT; k++) begin
            col_par = col_par ^ id[k*NIB_W +: NIB_W];
        end
    end

    always_comb begin
        frame.hdr  = '1;
        frame.rows = rows_w;
        frame.col  = col_par;
        frame.stop = 1'b0;
    end

    // XOR of all row parities equals XOR of all column parities (both cover every data bit).
    always_comb begin
        AST_ROW_COL_AGREE: assert (^row_par == ^col_par); // R3
    end

endmodule

// File: rtl/prox_frame_shifter.sv
module prox_frame_shifter
    import prox_frame_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   bit_en,
    input  logic   rpt_en,
    input  frame_t frame_in,
    output logic   busy,
    output logic   done,
    output logic   ser_out
);
    tx_state_t          state;
    logic [FRAME_W-1:0] sreg;
    logic [FRAME_W-1:0] held;
    logic [CNT_W-1:0]   bit_cnt;
    logic               last_bit;

    assign last_bit = (bit_cnt == CNT_W'(FRAME_W - 1));
    assign busy     = (state == TX_SEND);
    assign ser_out  = busy & sreg[FRAME_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= TX_IDLE;
            sreg    <= '0;
            held    <= '0;
            bit_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                TX_IDLE: begin
                    if (start) begin
                        sreg    <= frame_in;
                        held    <= frame_in;
                        bit_cnt <= '0;
                        state   <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (bit_en) begin
                        if (last_bit) begin
                            bit_cnt <= '0;
                            if (rpt_en) begin
                                sreg <= held;
                            end else begin
                                sreg  <= '0;
                                state <= TX_IDLE;
                                done  <= 1'b1;
                            end
                        end else begin
                            sreg    <= {sreg[FRAME_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    AST_START_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy); // R6
    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_en) |=> ($stable(sreg) && $stable(bit_cnt))); // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !bit_en) |=> $stable(held)); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_REPEAT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (busy && bit_en && last_bit && rpt_en) |=> (busy && sreg == held)); // R10
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ser_out)); // R11

endmodule

// File: rtl/prox_id_encoder.sv
module prox_id_encoder
    import prox_frame_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ID_W-1:0]     tag_id,
    input  logic                start,
    input  logic                bit_en,
    input  logic                rpt_en,
    output logic [HALF_W-1:0]   frame_hi,
    output logic [HALF_W-1:0]   frame_lo,
    output logic                busy,
    output logic                done,
    output logic                ser_out
);
    frame_t frame_w;

    prox_frame_build u_build (
        .id    (tag_id),
        .frame (frame_w)
    );

    prox_frame_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bit_en   (bit_en),
        .rpt_en   (rpt_en),
        .frame_in (frame_w),
        .busy     (busy),
        .done     (done),
        .ser_out  (ser_out)
    );

    assign frame_hi = frame_w[FRAME_W-1:HALF_W];
    assign frame_lo = frame_w[HALF_W-1:0];

endmodule

// File: tb/prox_id_encoder_tb.sv
`timescale 1ns/1ps
module prox_id_encoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [39:0] tag_id = '0;
    logic        start = 1'b0;
    logic        bit_en = 1'b0;
    logic        rpt_en = 1'b0;
    logic [31:0] frame_hi, frame_lo;
    logic        busy, done, ser_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    prox_id_encoder dut_i (
        .clk(clk), .rst(rst), .tag_id(tag_id), .start(start),
        .bit_en(bit_en), .rpt_en(rpt_en), .frame_hi(frame_hi),
        .frame_lo(frame_lo), .busy(busy), .done(done), .ser_out(ser_out)
    );

    function automatic logic [63:0] ref_frame(input logic [39:0] id);
        bit q[$];
        logic [63:0] f;
        logic [3:0] nb;
        logic [3:0] cp;
        cp = '0;
        for (int i = 0; i < 9; i++) q.push_back(1'b1);
        for (int r = 0; r < 10; r++) begin
            nb = id[39 - 4*r -: 4];
            for (int b = 3; b >= 0; b--) q.push_back(nb[b]);
            q.push_back(nb[0] ^ nb[1] ^ nb[2] ^ nb[3]);
            cp = cp ^ nb;
        end
        for (int b = 3; b >= 0; b--) q.push_back(cp[b]);
        q.push_back(1'b0);
        for (int i = 0; i < 64; i++) f[63 - i] = q[i];
        return f;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: a queue of pending bits
    bit        m_q[$];
    bit        m_busy = 0;
    bit        m_done = 0;
    logic [63:0] m_held;
    bit        model_on = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete(); m_busy = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (!m_busy) begin
                if (start) begin
                    m_held = ref_frame(tag_id);
                    m_q.delete();
                    for (int i = 63; i >= 0; i--) m_q.push_back(m_held[i]);
                    m_busy = 1;
                end
            end else if (bit_en) begin
                void'(m_q.pop_front());
                if (m_q.size() == 0) begin
                    if (rpt_en) begin
                        for (int i = 63; i >= 0; i--) m_q.push_back(m_held[i]);
                    end else begin
                        m_busy = 0; m_done = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && !finished) begin
            check("R4 frame words", {frame_hi, frame_lo}, ref_frame(tag_id));
            check("R6/R9 busy", 64'(busy), 64'(m_busy));
            check("R8 done", 64'(done), 64'(m_done));
            check("R7/R11 ser_out", 64'(ser_out), 64'((m_busy && m_q.size() > 0) ? m_q[0] : 1'b0));
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic field_checks(input logic [39:0] id);
        logic [63:0] f;
        logic [3:0] nb, cp;
        tag_id = id; #1;
        f = {frame_hi, frame_lo};
        cp = '0;
        check("R1 header", 64'(f[63:55]), 64'h1FF);
        for (int r = 0; r < 10; r++) begin
            nb = id[39 - 4*r -: 4];
            cp = cp ^ nb;
            check("R2 row", 64'(f[54 - 5*r -: 5]), 64'({nb, ^nb}));
        end
        check("R3 column parity", 64'(f[4:1]), 64'(cp));
        check("R4 stop", 64'(f[0]), 64'h0);
    endtask

    // Send one frame; strobe every cycle or sparsely
    task automatic run_frame(input logic [39:0] id, input bit sparse);
        tag_id = id; start = 1; step(1); start = 0;
        while (busy || m_busy) begin
            bit_en = sparse ? (($urandom % 3) == 0) : 1'b1;
            step(1);
        end
        bit_en = 0;
        step(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        step(2);
        check("R11 reset busy", 64'(busy), 64'h0);
        check("R11 reset ser_out", 64'(ser_out), 64'h0);
        rst = 0;
        step(1);

        tag_id = 40'h00_0000_1EBC; #1;
        check("R5 upper word", 64'(frame_hi), 64'hFF800000);
        check("R5 lower word", 64'(frame_lo), 64'h003EDF10);

        field_checks(40'h0);
        field_checks(40'hFF_FFFF_FFFF);
        field_checks(40'h12_3456_789A);
        for (int t = 0; t < 4; t++) field_checks({$urandom, $urandom} & 40'hFF_FFFF_FFFF);

        model_on = 1;
        run_frame(40'h00_0000_1EBC, 0);
        run_frame(40'hA5_5A_C3_3C_0F, 1);

        // R9: start and tag_id change mid-transmission are ignored
        tag_id = 40'h13_5792_4680; start = 1; step(1); start = 0;
        check("R6 busy after start", 64'(busy), 64'h1);
        bit_en = 1; step(10);
        start = 1; tag_id = 40'hFE_DCBA_9876; step(3); start = 0;
        while (busy) step(1);
        bit_en = 0; step(2);
        check("R9 idle after one frame", 64'(busy), 64'h0);

        // R10: repeat across a frame boundary
        rpt_en = 1; tag_id = 40'h0F_0F0F_0F0F; start = 1; step(1); start = 0;
        bit_en = 1; step(64);
        check("R10 still busy after 64 bits", 64'(busy), 64'h1);
        check("R10 no done on repeat", 64'(done), 64'h0);
        step(20);
        rpt_en = 0;
        while (busy) step(1);
        bit_en = 0; step(2);

        // R11: reset mid-transmission
        start = 1; step(1); start = 0; bit_en = 1; step(7);
        rst = 1; step(1); rst = 0; bit_en = 0;
        check("R11 reset mid-frame busy", 64'(busy), 64'h0);
        check("R11 reset mid-frame ser_out", 64'(ser_out), 64'h0);
        step(3);
        summary();
    end

endmodule